// File: doc/BRIEF.md
# Serial Slot Clock Mask Loader

This block builds the control word that gates the clocks a bridge hands out to its secondary bus. A 16-bit value is clocked in one bit at a time from an external shift-register chain. The bits are taken only while a load window is open, which is normally the time the secondary bus is held in reset. The finished word is written into a mask register. The register is decoded into one enable per secondary clock output: four option slots, five on-board devices and one feedback clock that returns to the bridge itself.

The four slots are not described by one bit each. Each slot supplies a pair of card-present bits. A slot's clock stays running when either bit of its pair is 0, and it is switched off only when both bits are 1. Device and feedback positions use one bit each, and a 1 turns the clock off. Positions that lead nowhere are therefore fed 1. A configuration-style write port can replace the mask at any time. The mask output always shows the two top bits as 0.

Top module: `slot_clk_mask_loader`

## Requirements
- R1: After reset the mask output reads 16'h0000 and all ten clock enables are 1.
- R2: Serial bits are taken least significant bit first. The first bit taken lands in mask bit 0 and the sixteenth lands in bit 15.
- R3: The mask register changes only on the clock edge that takes the sixteenth bit of a load, or on a configuration write. Partial loads leave it unchanged.
- R4: A bit is taken only in a cycle where both the load window and the shift enable are 1. Cycles with the shift enable at 0 capture nothing.
- R5: Closing the load window discards any partly received word. The next load starts again at bit 0.
- R6: Clock enable k (k = 0..3) belongs to slot k and reads mask bits 2k and 2k+1. It is 0 only when both bits are 1.
- R7: Clock enables 4..8 follow mask bits 8..12 in order. A mask bit of 1 gives an enable of 0.
- R8: Clock enable 9, the feedback clock, is the inverse of mask bit 13.
- R9: Mask bits 15:14 always read 0, whatever was loaded or written there.
- R10: A configuration write puts the written word, with bits 15:14 cleared, into the mask on the next edge. The write wins over a serial load that completes in the same cycle.
- R11: A window that stays open after a completed load accepts a further 16 bits, and these load the mask again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| load_win | input | 1 | Load window, high while serial loading is allowed |
| ser_din | input | 1 | Serial data bit |
| shift_en | input | 1 | Takes ser_din this cycle when high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| mask_q | output | 16 | Current mask, bits 15:14 read as 0 |
| clk_en | output | 10 | Per-output clock enables: [3:0] slots, [8:4] devices, [9] feedback |

## Verification
The bench tests the slot pairs one pair at a time. Patterns 01 and 10 must keep the slot clock running. A design that decodes one bit per slot would stop a populated slot. The bench also holds the shift enable low between bits and closes the window partway through a load. A design that counts idle cycles, or keeps a stale bit count, would then load a rotated word. The bench also makes a configuration write in the same cycle as the sixteenth serial bit, and loads all ones to check that the reserved bits still read 0.

// File: rtl/scm_pkg.sv
package scm_pkg;

    localparam int WORD_W  = 16;
    localparam int SLOT_N  = 4;
    localparam int DEV_N   = 5;
    localparam int DEV_LSB = 2 * SLOT_N;
    localparam int FB_BIT  = DEV_LSB + DEV_N;
    localparam int OUT_N   = SLOT_N + DEV_N + 1;
    localparam int CNT_W   = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] ctl_word_t;

    localparam ctl_word_t LIVE_BITS = {WORD_W{1'b1}} >> (WORD_W - FB_BIT - 1);

    typedef struct packed {
        ctl_word_t          word;
        logic [CNT_W-1:0]   cnt;
    } rx_state_t;

    function automatic ctl_word_t scrub(ctl_word_t w);
        return w & LIVE_BITS;
    endfunction

endpackage

// File: rtl/scm_shift_rx.sv
module scm_shift_rx
    import scm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      win,
    input  logic      sh_en,
    input  logic      din,
    output ctl_word_t word_o,
    output logic      done_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    rx_state_t st_q;
    logic      take;
    logic      last;
    ctl_word_t shifted;

    assign take    = win && sh_en;
    assign last    = take && (st_q.cnt == LAST);
    assign shifted = {din, st_q.word[WORD_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (!win) begin
            st_q.cnt <= '0;
        end else if (take) begin
            st_q.word <= shifted;
            st_q.cnt  <= last ? '0 : st_q.cnt + 1'b1;
        end
    end

    assign word_o = shifted;
    assign done_o = last;

    // R4: idle shift cycles keep the gathered bits
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !sh_en |=> $stable(st_q.word));

    // R5: a closed window restarts the bit count
    a_r5_window_restarts: assert property (@(posedge clk) disable iff (rst)
        !win |=> (st_q.cnt == '0));

endmodule

// File: rtl/scm_mask_reg.sv
module scm_mask_reg
    import scm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ld,
    input  ctl_word_t ld_word,
    input  logic      wr,
    input  ctl_word_t wr_word,
    output ctl_word_t q
);
    ctl_word_t mask_q;

    always_ff @(posedge clk) begin
        if (rst)       mask_q <= '0;
        else if (wr)   mask_q <= scrub(wr_word);
        else if (ld)   mask_q <= scrub(ld_word);
    end

    assign q = mask_q;

    // R10: a write lands on the next edge and beats a serial load
    a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr |=> (q == scrub($past(wr_word))));

    // R3: no source, no change
    a_r3_hold_between: assert property (@(posedge clk) disable iff (rst)
        (!wr && !ld) |=> $stable(q));

    // R9: reserved bits stay clear
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        q[WORD_W-1:FB_BIT+1] == '0);

endmodule

// File: rtl/scm_en_decode.sv
module scm_en_decode
    import scm_pkg::*;
(
    input  logic [FB_BIT:0]  live,
    output logic [OUT_N-1:0] en
);
    genvar s, d;
    generate
        for (s = 0; s < SLOT_N; s++) begin : g_slot
            assign en[s] = ~(live[2*s] & live[2*s+1]);
        end
        for (d = 0; d < DEV_N; d++) begin : g_dev
            assign en[SLOT_N+d] = ~live[DEV_LSB+d];
        end
    endgenerate

    assign en[OUT_N-1] = ~live[FB_BIT];

endmodule

// File: rtl/slot_clk_mask_loader.sv
module slot_clk_mask_loader
    import scm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_win,
    input  logic              ser_din,
    input  logic              shift_en,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] mask_q,
    output logic [OUT_N-1:0]  clk_en
);
    ctl_word_t rx_word;
    logic      rx_done;
    ctl_word_t mask_w;

    scm_shift_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .win    (load_win),
        .sh_en  (shift_en),
        .din    (ser_din),
        .word_o (rx_word),
        .done_o (rx_done)
    );

    scm_mask_reg u_mask (
        .clk     (clk),
        .rst     (rst),
        .ld      (rx_done),
        .ld_word (rx_word),
        .wr      (cfg_wr),
        .wr_word (cfg_wdata),
        .q       (mask_w)
    );

    scm_en_decode u_dec (
        .live (mask_w[FB_BIT:0]),
        .en   (clk_en)
    );

    assign mask_q = mask_w;

    // R1: leaving reset, every clock runs
    a_r1_reset_enables: assert property (@(posedge clk)
        $fell(rst) |-> (&clk_en));

    // R6: an all-zero mask never stops a clock
    a_r6_zero_mask_runs: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> (&clk_en));

endmodule

// File: tb/slot_clk_mask_loader_tb.sv
module slot_clk_mask_loader_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_win = 1'b0;
    logic        ser_din = 1'b0;
    logic        shift_en = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] mask_q;
    logic [9:0]  clk_en;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit finished = 1'b0;

    // reference state
    logic [15:0] m_mask = '0;
    logic [15:0] m_acc  = '0;
    int          m_cnt  = 0;

    always #10 clk = ~clk;

    slot_clk_mask_loader dut_i (
        .clk(clk), .rst(rst), .load_win(load_win), .ser_din(ser_din),
        .shift_en(shift_en), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .mask_q(mask_q), .clk_en(clk_en)
    );

    function automatic logic [9:0] exp_en(logic [15:0] m);
        logic [9:0] e;
        for (int k = 0; k < 4; k++) e[k] = !(m[2*k] == 1'b1 && m[2*k+1] == 1'b1);
        for (int k = 0; k < 5; k++) e[4+k] = (m[8+k] == 1'b0);
        e[9] = (m[13] == 1'b0);
        return e;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mask = '0; m_acc = '0; m_cnt = 0;
        end else begin
            logic [15:0] nxt;
            bit          fin;
            nxt = m_mask; fin = 0;
            if (!load_win) m_cnt = 0;
            else if (shift_en) begin
                m_acc[m_cnt] = ser_din;
                m_cnt = m_cnt + 1;
                if (m_cnt == 16) begin fin = 1; m_cnt = 0; end
            end
            if (fin) nxt = m_acc;
            if (cfg_wr) nxt = cfg_wdata;
            nxt[15:14] = 2'b00;
            m_mask = nxt;
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (mask_q !== m_mask || clk_en !== exp_en(m_mask)) begin
                errors++;
                $display("FAIL %s: mask=%h en=%h expected mask=%h en=%h",
                         cur_req, mask_q, clk_en, m_mask, exp_en(m_mask));
            end
        end
    end

    task automatic tick();
        @(posedge clk); #5;
    endtask

    task automatic check_val(string req, logic [15:0] em, logic [9:0] ee);
        @(negedge clk); #1;
        checks++;
        if (mask_q !== em || clk_en !== ee) begin
            errors++;
            $display("FAIL %s: mask=%h en=%h expected mask=%h en=%h",
                     req, mask_q, clk_en, em, ee);
        end
    endtask

    task automatic send_word(logic [15:0] w, bit gaps);
        for (int i = 0; i < 16; i++) begin
            load_win = 1'b1; shift_en = 1'b1; ser_din = w[i];
            tick();
            if (gaps) begin
                shift_en = 1'b0; ser_din = ~w[i];
                tick();
            end
        end
        shift_en = 1'b0;
    endtask

    task automatic close_win();
        load_win = 1'b0; shift_en = 1'b0;
        tick();
    endtask

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        cur_req = "R1";
        check_val("R1", 16'h0000, 10'h3FF);
        @(posedge clk); #5;

        cur_req = "R2";
        send_word(16'h00FF, 0); close_win();
        check_val("R2", 16'h00FF, 10'h3F0);
        @(posedge clk); #5;

        cur_req = "R6";
        send_word(16'h0006, 0); close_win();
        check_val("R6", 16'h0006, 10'h3FF);
        @(posedge clk); #5;
        send_word(16'h000C, 0); close_win();
        check_val("R6", 16'h000C, 10'h3FD);
        @(posedge clk); #5;

        cur_req = "R7";
        send_word(16'h2100, 0); close_win();
        check_val("R8", 16'h2100, 10'h1EF);
        @(posedge clk); #5;

        cur_req = "R9";
        send_word(16'hFFFF, 0); close_win();
        check_val("R9", 16'h3FFF, 10'h000);
        @(posedge clk); #5;

        cur_req = "R4";
        send_word(16'h1234, 1); close_win();
        check_val("R4", 16'h1234, exp_en(16'h1234));
        @(posedge clk); #5;

        cur_req = "R5";
        for (int i = 0; i < 7; i++) begin
            load_win = 1'b1; shift_en = 1'b1; ser_din = 1'b1; tick();
        end
        shift_en = 1'b0;
        check_val("R3", 16'h1234, exp_en(16'h1234));
        @(posedge clk); #5;
        close_win();
        send_word(16'h0A05, 0); close_win();
        check_val("R5", 16'h0A05, exp_en(16'h0A05));
        @(posedge clk); #5;

        cur_req = "R11";
        send_word(16'h0003, 0);
        send_word(16'h0300, 0); close_win();
        check_val("R11", 16'h0300, exp_en(16'h0300));
        @(posedge clk); #5;

        cur_req = "R10";
        cfg_wr = 1'b1; cfg_wdata = 16'hC0F0; tick(); cfg_wr = 1'b0;
        check_val("R10", 16'h00F0, 10'h3F3);
        @(posedge clk); #5;
        for (int i = 0; i < 16; i++) begin
            load_win = 1'b1; shift_en = 1'b1; ser_din = 1'b1;
            if (i == 15) begin cfg_wr = 1'b1; cfg_wdata = 16'h0041; end
            tick();
        end
        cfg_wr = 1'b0; close_win();
        check_val("R10", 16'h0041, exp_en(16'h0041));
        @(posedge clk); #5;

        cur_req = "R1";
        rst = 1'b1; tick(); rst = 1'b0; tick();
        check_val("R1", 16'h0000, 10'h3FF);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule